// File: doc/BRIEF.md
# Two-Line Edge-Triggered Interrupt Collector

This block gathers a bank of asynchronous event inputs and turns them into two active-low interrupt request lines, one per host agent. Every input first passes through a two-stage synchronizer. A shared trigger-selection register then decides, for each input, whether a rising edge, a falling edge, either edge or nothing at all records an event. An input whose two trigger bits are both zero is inert. It never records anything, so it acts as a permanently masked source.

Each host line keeps its own pending-status register and its own mask register. A detected event marks the source pending on both lines at once. Each line raises its request while any pending source is not masked on that line. A second event that arrives while a source is still pending is held in a one-deep backlog, so the source becomes pending again after the first acknowledge. A control bit selects how software acknowledges. In read-to-clear mode, reading a status byte clears the bits it returned. In write-one-to-clear mode, writing ones clears the matching bits. Two write-only test registers force status bits on either line.

A byte-wide register port gives access to all registers through an address, write data, a read strobe and a write strobe. Read data is registered. Address map (5-bit address): status of line A at 0-3, mask of line A at 4-7, status of line B at 8-11, mask of line B at 12-15, force register of line A at 16-19, force register of line B at 20-23, trigger selection at 24 and up, control at 31. Addresses with no register behind them read zero.

Top module: `sih_bank`

## Requirements
- R1: After reset, all status bits are 0, all mask bits are 1, all trigger bits are 0, the control register is 0, both `irq_n_o` bits are 1 and `rdata_o` is 0.
- R2: The trigger bits of source i sit in the trigger byte at address 24 + i/4, at bit offset 2*(i mod 4). The upper bit of the pair enables rising-edge detection and the lower bit enables falling-edge detection. With both bits set, either edge is detected.
- R3: A source whose two trigger bits are both 0 never sets its status bit on either line, whatever its input does.
- R4: After an enabled edge on `src_i`, the status bit is set on the 3rd rising clock edge. An unmasked line's `irq_n_o` goes low on the 4th rising clock edge.
- R5: Each line has a private status register and a private mask register, and a mask bit of 1 blocks that source on that line only. `irq_n_o[L]` is registered: it is 0 one cycle after any status bit of line L is 1 while its mask bit is 0, and it is 1 one cycle after no such bit exists.
- R6: With control bit 0 set to 1 (read-to-clear), a read of a status byte returns its bits and clears them. Writes to status bytes have no effect in this mode.
- R7: With control bit 0 at 0 (write-one-to-clear), writing a 1 to a status bit clears it and writing 0 leaves it. Reads do not change status. Status bits change only through events or register accesses.
- R8: An event on a source whose status bit is already pending is remembered. After the acknowledge that clears the bit, the bit is 1 again, and a second acknowledge clears it.
- R9: Writing a 1 into a bit of a line's force register sets that status bit on that line only. The force registers read as zero.
- R10: If an event and an acknowledge hit the same status bit in the same cycle, the bit ends up set.
- R11: Status bits for source indices at or above NSRC (default 22) read as 0 and cannot be set. For example, forcing 0xFF into status byte 2 reads back 0x3F. Status bytes at or past ceil(NSRC/8) read 0.
- R12: Multi-byte registers are little-endian: byte offset 0 holds sources 0..7. `rdata_o` shows the addressed byte on the cycle after the cycle in which `rd_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | NSRC | Asynchronous event inputs |
| addr_i | input | 5 | Register byte address |
| wdata_i | input | 8 | Write data |
| rd_i | input | 1 | Read strobe, one cycle per byte |
| wr_i | input | 1 | Write strobe, one cycle per byte |
| rdata_o | output | 8 | Registered read data |
| irq_n_o | output | 2 | Active-low interrupt requests, bit 0 line A, bit 1 line B |

## Verification
An input change becomes a status bit three rising edges later and an interrupt level four edges later. The bench toggles sources on a falling edge and checks `irq_n_o` on the third and the fourth following falling edge, expecting the first check to still see 1. A register write takes effect at the edge that samples it, and `irq_n_o` follows one edge after that. The bench therefore checks an interrupt level once right after the write and again one cycle later. The same-cycle event/acknowledge case lines the acknowledge write up with the third edge after the toggle, and randomly chosen sources and trigger codes are read back four cycles after each toggle.

// File: rtl/sih_pkg.sv
package sih_pkg;

  // Register groups selected by addr[4:2] for the lower 24 addresses.
  typedef enum logic [2:0] {
    GRP_STA  = 3'd0,
    GRP_MKA  = 3'd1,
    GRP_STB  = 3'd2,
    GRP_MKB  = 3'd3,
    GRP_FRCA = 3'd4,
    GRP_FRCB = 3'd5,
    GRP_TRG0 = 3'd6,
    GRP_TRG1 = 3'd7
  } grp_e;

  localparam logic [4:0] CTRL_ADDR = 5'd31;

  function automatic int unsigned bytes_for(input int unsigned bits);
    return (bits + 7) / 8;
  endfunction

  // Bit index of the falling-enable bit of a source; rising is one above.
  function automatic int unsigned trig_bit(input int unsigned src);
    return (src / 4) * 8 + (src % 4) * 2;
  endfunction

  function automatic logic [31:0] low_ones(input int unsigned n);
    if (n >= 32) return '1;
    return (32'd1 << n) - 32'd1;
  endfunction

  function automatic logic [63:0] put_byte(input logic [2:0] b, input logic [7:0] d);
    return {56'd0, d} << (6'(b) * 6'd8);
  endfunction

  function automatic logic [7:0] take_byte(input logic [63:0] v, input logic [2:0] b);
    return v[6'(b) * 6'd8 +: 8];
  endfunction

endpackage

// File: rtl/sih_sync_edge.sv
module sih_sync_edge #(
  parameter int unsigned N = 22
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   src_i,
  input  logic [2*N-1:0] trig_i,
  output logic [N-1:0]   ev_o
);
  import sih_pkg::*;

  logic [N-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= src_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_src
    localparam int unsigned FB = trig_bit(i);
    logic rise_en, fall_en;
    assign fall_en = trig_i[FB];
    assign rise_en = trig_i[FB+1];
    assign ev_o[i] = (rise_en & sync_q[i] & ~prev_q[i]) |
                     (fall_en & ~sync_q[i] & prev_q[i]);
  end

  // An event needs a level change between the last two synchronized samples.
  p_event_on_change_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_o & ~(sync_q ^ prev_q)) == '0);

endmodule

// File: rtl/sih_line.sv
module sih_line #(
  parameter int unsigned NSRC = 22
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [8*sih_pkg::bytes_for(NSRC)-1:0] ev_i,
  input  logic [8*sih_pkg::bytes_for(NSRC)-1:0] frc_i,
  input  logic [8*sih_pkg::bytes_for(NSRC)-1:0] clr_i,
  input  logic [sih_pkg::bytes_for(NSRC)-1:0]   mask_we_i,
  input  logic [7:0]                    wdata_i,
  output logic [8*sih_pkg::bytes_for(NSRC)-1:0] status_o,
  output logic [8*sih_pkg::bytes_for(NSRC)-1:0] mask_o,
  output logic                          irq_n_o
);
  import sih_pkg::*;

  localparam int unsigned NB = bytes_for(NSRC);
  localparam int unsigned W  = 8 * NB;
  localparam logic [31:0]  VLD32 = low_ones(NSRC);
  localparam logic [W-1:0] VLD   = VLD32[W-1:0];

  logic [W-1:0] st_q, again_q, mask_q;
  logic [W-1:0] set_eff, ack_hit, st_d, again_d;
  logic         irq_q;

  assign set_eff = (ev_i | frc_i) & VLD;
  assign ack_hit = clr_i & st_q;
  assign st_d    = set_eff | (st_q & ~clr_i) | (ack_hit & again_q);
  assign again_d = (again_q & ~ack_hit) | (st_q & ~clr_i & set_eff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= '0;
      again_q <= '0;
      irq_q   <= 1'b1;
    end else begin
      st_q    <= st_d;
      again_q <= again_d;
      irq_q   <= ~|(st_q & ~mask_q);
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_mask
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            mask_q[8*b +: 8] <= 8'hFF;
      else if (mask_we_i[b]) mask_q[8*b +: 8] <= wdata_i;
    end
  end

  assign status_o = st_q;
  assign mask_o   = mask_q;
  assign irq_n_o  = irq_q;

  p_set_beats_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((st_q & $past(set_eff & clr_i)) == $past(set_eff & clr_i)));

  p_backlog_reasserts_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(ack_hit & again_q) & ~st_q) == '0));

  p_unused_bits_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q & ~VLD) == '0);

  p_irq_asserts_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q & ~mask_q) != '0) |=> !irq_n_o);

  p_irq_releases_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q & ~mask_q) == '0) |=> irq_n_o);

endmodule

// File: rtl/sih_bank.sv
module sih_bank #(
  parameter int unsigned NSRC = 22
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic [4:0]      addr_i,
  input  logic [7:0]      wdata_i,
  input  logic            rd_i,
  input  logic            wr_i,
  output logic [7:0]      rdata_o,
  output logic [1:0]      irq_n_o
);
  import sih_pkg::*;

  localparam int unsigned NB = bytes_for(NSRC);
  localparam int unsigned W  = 8 * NB;
  localparam int unsigned TW = 2 * NSRC;
  localparam int unsigned TB = bytes_for(TW);

  initial begin
    if (NSRC < 1 || NSRC > 24) $fatal(1, "sih_bank: NSRC must be 1..24");
  end

  logic [TW-1:0] trig_q;
  logic          cor_q;
  logic [7:0]    rdata_q;
  logic [NSRC-1:0] ev_raw;
  logic [W-1:0]  ev_w;
  logic [W-1:0]  st_a, st_b, mk_a, mk_b;
  logic [W-1:0]  clr_a, clr_b, frc_a, frc_b;
  logic [NB-1:0] mwe_a, mwe_b;
  logic [2:0]    grp;
  logic [2:0]    bsel;
  logic          is_trg, is_ctrl;
  logic [W-1:0]  wr_vec, rd_vec;
  logic [7:0]    rmux;

  assign grp     = addr_i[4:2];
  assign bsel    = {1'b0, addr_i[1:0]};
  assign is_trg  = (addr_i[4:3] == 2'b11) && (32'(addr_i[2:0]) < TB);
  assign is_ctrl = (addr_i == CTRL_ADDR);
  assign wr_vec  = W'(put_byte(bsel, wdata_i));
  assign rd_vec  = W'(put_byte(bsel, 8'hFF));

  sih_sync_edge #(.N(NSRC)) u_edge (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .trig_i(trig_q), .ev_o(ev_raw)
  );
  assign ev_w = W'(ev_raw);

  // Acknowledge: read-to-clear uses the read strobe, otherwise write ones.
  always_comb begin
    clr_a = '0;
    clr_b = '0;
    if (cor_q) begin
      if (rd_i && grp == GRP_STA && !addr_i[4]) clr_a = rd_vec & st_a;
      if (rd_i && grp == GRP_STB && !addr_i[4]) clr_b = rd_vec & st_b;
    end else begin
      if (wr_i && grp == GRP_STA) clr_a = wr_vec;
      if (wr_i && grp == GRP_STB) clr_b = wr_vec;
    end
  end

  assign frc_a = (wr_i && grp == GRP_FRCA) ? wr_vec : '0;
  assign frc_b = (wr_i && grp == GRP_FRCB) ? wr_vec : '0;

  for (genvar b = 0; b < NB; b++) begin : g_mwe
    assign mwe_a[b] = wr_i && grp == GRP_MKA && 32'(bsel) == b;
    assign mwe_b[b] = wr_i && grp == GRP_MKB && 32'(bsel) == b;
  end

  sih_line #(.NSRC(NSRC)) u_line_a (
    .clk(clk), .rst_n(rst_n), .ev_i(ev_w), .frc_i(frc_a), .clr_i(clr_a),
    .mask_we_i(mwe_a), .wdata_i(wdata_i), .status_o(st_a), .mask_o(mk_a),
    .irq_n_o(irq_n_o[0])
  );

  sih_line #(.NSRC(NSRC)) u_line_b (
    .clk(clk), .rst_n(rst_n), .ev_i(ev_w), .frc_i(frc_b), .clr_i(clr_b),
    .mask_we_i(mwe_b), .wdata_i(wdata_i), .status_o(st_b), .mask_o(mk_b),
    .irq_n_o(irq_n_o[1])
  );

  // Shared trigger register and control bit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q <= '0;
      cor_q  <= 1'b0;
    end else if (wr_i) begin
      if (is_ctrl) cor_q <= wdata_i[0];
      if (is_trg) begin
        for (int j = 0; j < TW; j++) begin
          if (j / 8 == int'(addr_i[2:0])) trig_q[j] <= wdata_i[j % 8];
        end
      end
    end
  end

  always_comb begin
    rmux = 8'h00;
    if (is_ctrl)     rmux = {7'd0, cor_q};
    else if (is_trg) rmux = take_byte(64'(trig_q), addr_i[2:0]);
    else begin
      case (grp)
        GRP_STA: rmux = take_byte(64'(st_a), bsel);
        GRP_MKA: rmux = take_byte(64'(mk_a), bsel);
        GRP_STB: rmux = take_byte(64'(st_b), bsel);
        GRP_MKB: rmux = take_byte(64'(mk_b), bsel);
        default: rmux = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rdata_q <= 8'h00;
    else if (rd_i) rdata_q <= rmux;
  end

  assign rdata_o = rdata_q;

  // Without any register access, a pending bit of line A never drops.
  p_hold_until_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_i && !wr_i) |=> ((st_a & $past(st_a)) == $past(st_a)));

  // Read data only moves on a read strobe.
  p_rdata_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> $stable(rdata_o));

endmodule

// File: tb/sih_bank_tb_top.sv
`timescale 1ns/1ps
module sih_bank_tb_top;
  localparam int unsigned NSRC = 22;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] src = '0;
  logic [4:0]      addr = '0;
  logic [7:0]      wdata = '0;
  logic            rd = 1'b0, wr = 1'b0;
  logic [7:0]      rdata;
  logic [1:0]      irq_n;

  int tests = 0;
  int fails = 0;
  logic [47:0] trig_m = '0;

  always #2.5 clk = ~clk;

  sih_bank #(.NSRC(NSRC)) dut_i (
    .clk(clk), .rst_n(rst_n), .src_i(src), .addr_i(addr), .wdata_i(wdata),
    .rd_i(rd), .wr_i(wr), .rdata_o(rdata), .irq_n_o(irq_n)
  );

  function automatic logic exp_event(input logic [1:0] code, input logic newv);
    return newv ? code[1] : code[0];
  endfunction

  function automatic logic [4:0] trig_addr(input int unsigned i);
    return 5'(24 + i / 4);
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(posedge clk); @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [4:0] a, output logic [7:0] d);
    addr = a; rd = 1'b1;
    @(posedge clk); @(negedge clk);
    d = rdata; rd = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [4:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd_reg(a, v);
    check(req, v, exp);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    tests++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    check("R1 irq", {6'd0, irq_n}, 8'h03);
    check("R1 rdata", rdata, 8'h00);
    rd_chk("R1 statusA", 5'd0, 8'h00);
    rd_chk("R1 maskA", 5'd4, 8'hFF);
    rd_chk("R1 statusB", 5'd8, 8'h00);
    rd_chk("R1 maskB b2", 5'd14, 8'hFF);
    rd_chk("R1 trig", 5'd24, 8'h00);
    rd_chk("R1 ctrl", 5'd31, 8'h00);

    // R9 force, R5 private status and mask
    wr_reg(5'd16, 8'h08);
    rd_chk("R9 force line A", 5'd0, 8'h08);
    rd_chk("R9 line B untouched", 5'd8, 8'h00);
    rd_chk("R9 force reads zero", 5'd16, 8'h00);
    check("R5 masked no irq", {6'd0, irq_n}, 8'h03);
    wr_reg(5'd4, 8'hF7);
    check("R5 irq registered", {6'd0, irq_n}, 8'h03);
    @(negedge clk);
    check("R5 irq A low", {6'd0, irq_n}, 8'h02);

    // R7 write-one-to-clear
    rd_chk("R7 read keeps", 5'd0, 8'h08);
    rd_chk("R7 read keeps again", 5'd0, 8'h08);
    wr_reg(5'd0, 8'h00);
    rd_chk("R7 zero write no effect", 5'd0, 8'h08);
    wr_reg(5'd0, 8'h08);
    rd_chk("R7 cleared", 5'd0, 8'h00);
    check("R5 irq released", {6'd0, irq_n}, 8'h03);

    // R6 read-to-clear
    wr_reg(5'd31, 8'h01);
    rd_chk("R6 ctrl", 5'd31, 8'h01);
    wr_reg(5'd16, 8'h08);
    wr_reg(5'd0, 8'hFF);
    rd_chk("R6 read returns", 5'd0, 8'h08);
    rd_chk("R6 read cleared", 5'd0, 8'h00);
    wr_reg(5'd4, 8'hFF);
    wr_reg(5'd31, 8'h00);

    // R11 bits past NSRC, R12 byte order
    wr_reg(5'd18, 8'hFF);
    rd_chk("R11 top byte", 5'd2, 8'h3F);
    rd_chk("R11 absent byte", 5'd3, 8'h00);
    rd_chk("R12 byte0 untouched", 5'd0, 8'h00);
    wr_reg(5'd2, 8'hFF);
    rd_chk("R11 cleared", 5'd2, 8'h00);

    // R8 backlog of a second event
    trig_m[1:0] = 2'b11;
    wr_reg(trig_addr(0), trig_m[7:0]);
    src[0] = 1'b1; repeat (4) @(negedge clk);
    src[0] = 1'b0; repeat (4) @(negedge clk);
    rd_chk("R8 pending", 5'd0, 8'h01);
    wr_reg(5'd0, 8'h01);
    rd_chk("R8 reasserted", 5'd0, 8'h01);
    wr_reg(5'd0, 8'h01);
    rd_chk("R8 second clear", 5'd0, 8'h00);
    wr_reg(5'd8, 8'hFF); wr_reg(5'd8, 8'hFF);
    rd_chk("R8 line B cleared", 5'd8, 8'h00);

    // R10 event and acknowledge in the same cycle
    src[0] = 1'b1;
    @(negedge clk); @(negedge clk);
    wr_reg(5'd0, 8'h01);
    rd_chk("R10 set wins", 5'd0, 8'h01);
    wr_reg(5'd0, 8'h01);
    rd_chk("R10 no backlog", 5'd0, 8'h00);
    wr_reg(5'd8, 8'hFF);

    // R4 latency and R2 rising-only on source 1
    wr_reg(5'd12, 8'hFD);
    trig_m[3:2] = 2'b10;
    wr_reg(trig_addr(1), trig_m[7:0]);
    rd_chk("R2 trig readback", 5'd24, 8'h0B);
    src[1] = 1'b1;
    @(negedge clk); @(negedge clk); @(negedge clk);
    check("R4 irq not yet", {6'd0, irq_n}, 8'h03);
    @(negedge clk);
    check("R4 irq B low", {6'd0, irq_n}, 8'h01);
    rd_chk("R4 status B", 5'd8, 8'h02);
    wr_reg(5'd8, 8'h02); wr_reg(5'd0, 8'h02);
    src[1] = 1'b0; repeat (4) @(negedge clk);
    rd_chk("R2 falling ignored", 5'd8, 8'h00);
    wr_reg(5'd12, 8'hFF);

    // R3 inert source
    src[5] = 1'b1; repeat (4) @(negedge clk);
    src[5] = 1'b0; repeat (4) @(negedge clk);
    rd_chk("R3 inert source", 5'd0, 8'h00);

    // R2/R3 random sources and trigger codes
    for (int it = 0; it < 40; it++) begin
      int unsigned i;
      logic [1:0] code;
      logic nv;
      logic [7:0] expb;
      i = $urandom_range(NSRC - 1, 0);
      code = 2'($urandom_range(3, 0));
      trig_m[2*i +: 2] = code;
      wr_reg(trig_addr(i), trig_m[8*(i/4) +: 8]);
      nv = ~src[i];
      src[i] = nv;
      repeat (4) @(negedge clk);
      expb = exp_event(code, nv) ? (8'h01 << (i % 8)) : 8'h00;
      rd_chk("R2 random line A", 5'(i / 8), expb);
      rd_chk("R3 random line B", 5'(8 + i / 8), expb);
      wr_reg(5'(i / 8), 8'hFF);
      wr_reg(5'(8 + i / 8), 8'hFF);
    end

    finish_run();
  end
endmodule